// File: doc/BRIEF.md
# Receive Buffer Ready-to-Send Flow Controller

This block decides when a serial receiver tells its link partner to stop sending. It watches how many words sit in the receive buffer, where the buffer is the register the host reads plus the small queue behind it. It drives an active-low ready-to-send line from that count. A stop is never caused by the fill level on its own. The line is withdrawn only when the buffer is already at its threshold and the start bit of one more word is seen. One configuration bit picks between two thresholds: two words or four words. The line comes back once the level drops below the chosen threshold.

Each withdrawal lasts at least as many bit times as the configured data length of 5 to 8 bits. A down-counter clocked by the baud bit-time tick enforces this. A reassert condition that shows up earlier is held off until the counter reaches zero. The condition is then checked again at that point. When automatic control is off, the line simply follows a manual bit.

Top module: `rx_rts_flow`

## Requirements
- R1: After reset, with automatic mode on and an empty buffer, `rts_n` is low (asserted).
- R2: With `thr_sel`=0 in automatic mode, a `start_det` pulse while the level is 2 or more drives `rts_n` high after the next clock edge.
- R3: A fill level at or above the threshold without `start_det`, or a `start_det` while the level is below the threshold, leaves `rts_n` low.
- R4: With `thr_sel`=0, once the timer has expired, a level of 1 or less drives `rts_n` low after the next clock edge.
- R5: With `thr_sel`=1 in automatic mode, a `start_det` pulse while the level is 4 or more drives `rts_n` high. At level 3 it does not.
- R6: With `thr_sel`=1, once the timer has expired, a level of 3 or less drives `rts_n` low.
- R7: When `rts_n` goes high, a timer is loaded with 5 + `wlen` (`wlen` 0..3 encodes 5..8 data bits). Each `bit_tick` decrements it, and `rts_n` stays high until it reaches zero.
- R8: When the timer expires, `rts_n` returns low only if the reassert condition holds at that time. Otherwise it stays high until the condition holds.
- R9: With `auto_en`=0, `rts_n` equals the inverse of `man_assert` combinationally. Turning automatic mode back on starts from the asserted state with the timer cleared.
- R10: The level used is `fill_cnt` minus one when `host_read` is high in the same cycle and `fill_cnt` is nonzero. Otherwise it is `fill_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_cnt | input | CNT_W | Words in the receive buffer, read register included |
| start_det | input | 1 | One-cycle pulse: start bit of a new word detected |
| host_read | input | 1 | One-cycle pulse: host reads a word this cycle |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| auto_en | input | 1 | 1 = automatic flow control, 0 = manual |
| thr_sel | input | 1 | 0 = two-word threshold, 1 = four-word threshold |
| man_assert | input | 1 | Manual mode: 1 asserts the line (drives it low) |
| wlen | input | 2 | Data length code, 0..3 for 5..8 bits |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
Suppose the held-off flag or the width counter goes wrong inside the block. The fault reaches `rts_n` on the very next edge as an early stop or an early release. A missed stop on a start bit at threshold shows as `rts_n` staying low in the cycle after the pulse. A short or miscounted timer shows as `rts_n` falling before the expected tick count, or one edge late. An error in the level arithmetic appears only at the boundary counts. For that reason the stimulus sits exactly on 1/2 and 3/4 words, including a `host_read` in the same cycle.

// File: rtl/rts_pkg.sv
package rts_pkg;
   localparam int unsigned BASE_BITS = 5;

   function automatic logic [3:0] hold_bits(input logic [1:0] code);
      return 4'(BASE_BITS) + {2'b00, code};
   endfunction
endpackage

// File: rtl/rts_level_cmp.sv
module rts_level_cmp #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned LO_THR      = 2,
   parameter int unsigned HI_THR      = 4,
   parameter bit          READ_ADJUST = 1'b1
) (
   input  logic [CNT_W-1:0] fill_cnt,
   input  logic             host_read,
   input  logic             thr_sel,
   output logic             at_thr,
   output logic             below_thr
);
   logic [CNT_W-1:0] level;
   logic [CNT_W-1:0] thr;

   generate
      if (READ_ADJUST) begin : g_adj
         always_comb begin
            if (host_read && (fill_cnt != '0)) level = fill_cnt - CNT_W'(1);
            else                                level = fill_cnt;
         end
      end else begin : g_raw
         logic unused_rd;
         assign unused_rd = host_read;
         assign level     = fill_cnt;
      end
   endgenerate

   assign thr       = thr_sel ? CNT_W'(HI_THR) : CNT_W'(LO_THR);
   assign at_thr    = (level >= thr);
   assign below_thr = (level <  thr);
endmodule

// File: rtl/rts_width_timer.sv
module rts_width_timer #(
   parameter int unsigned TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   input  logic             tick,
   output logic [TMR_W-1:0] count,
   output logic             expired
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clr)                    count <= '0;
      else if (load)                   count <= load_val;
      else if (tick && (count != '0))  count <= count - TMR_W'(1);
   end

   assign expired = (count == '0);
endmodule

// File: rtl/rx_rts_flow.sv
module rx_rts_flow #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned DEPTH       = 5,
   parameter int unsigned LO_THR      = 2,
   parameter int unsigned HI_THR      = 4,
   parameter int unsigned WLEN_W      = 2,
   parameter bit          READ_ADJUST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  fill_cnt,
   input  logic              start_det,
   input  logic              host_read,
   input  logic              bit_tick,
   input  logic              auto_en,
   input  logic              thr_sel,
   input  logic              man_assert,
   input  logic [WLEN_W-1:0] wlen,
   output logic              rts_n
);
   localparam int unsigned MAX_HOLD = rts_pkg::BASE_BITS + (1 << WLEN_W) - 1;
   localparam int unsigned TMR_W    = $clog2(MAX_HOLD + 1);

   if (WLEN_W != 2) begin : g_bad_wlen
      $error("rx_rts_flow: WLEN_W must be 2");
   end
   if (LO_THR == 0 || LO_THR >= HI_THR) begin : g_bad_thr
      $error("rx_rts_flow: need 0 < LO_THR < HI_THR");
   end
   if (HI_THR >= DEPTH || DEPTH >= (1 << CNT_W)) begin : g_bad_depth
      $error("rx_rts_flow: need HI_THR < DEPTH < 2**CNT_W");
   end

   logic             at_thr;
   logic             below_thr;
   logic             off_q;
   logic             stop_now;
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_done;

   rts_level_cmp #(
      .CNT_W(CNT_W), .LO_THR(LO_THR), .HI_THR(HI_THR), .READ_ADJUST(READ_ADJUST)
   ) u_cmp (
      .fill_cnt (fill_cnt),
      .host_read(host_read),
      .thr_sel  (thr_sel),
      .at_thr   (at_thr),
      .below_thr(below_thr)
   );

   assign stop_now = auto_en && !off_q && start_det && at_thr;

   rts_width_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!auto_en),
      .load    (stop_now),
      .load_val(TMR_W'(rts_pkg::hold_bits(wlen))),
      .tick    (bit_tick),
      .count   (tmr_cnt),
      .expired (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           off_q <= 1'b0;
      else if (!auto_en)                    off_q <= 1'b0;
      else if (stop_now)                    off_q <= 1'b1;
      else if (off_q && tmr_done && below_thr) off_q <= 1'b0;
   end

   assign rts_n = auto_en ? off_q : !man_assert;
endmodule

// File: rtl/rx_rts_flow_chk.sv
module rx_rts_flow_chk #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned LO_THR = 2,
   parameter int unsigned HI_THR = 4,
   parameter int unsigned TMR_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fill_cnt,
   input logic             start_det,
   input logic             host_read,
   input logic             auto_en,
   input logic             thr_sel,
   input logic [1:0]       wlen,
   input logic             rts_n,
   input logic [TMR_W-1:0] tmr_cnt
);
   logic [CNT_W-1:0] lvl;
   logic [CNT_W-1:0] lim;
   assign lvl = (host_read && fill_cnt != '0) ? fill_cnt - CNT_W'(1) : fill_cnt;
   assign lim = thr_sel ? CNT_W'(HI_THR) : CNT_W'(LO_THR);

   // R2 / R5: a stop is only ever caused by a start bit at threshold
   assert_stop_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && $rose(rts_n)) |-> ($past(start_det) && $past(lvl) >= $past(lim)));

   // R7: the timer is loaded from the word length when the line goes high
   assert_timer_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && $rose(rts_n)) |-> (tmr_cnt == TMR_W'(5) + TMR_W'($past(wlen))));

   // R8: release only after the timer has run out
   assert_release_after_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && $fell(rts_n)) |-> ($past(tmr_cnt) == '0));

   // R4 / R6: release only when the level is below the threshold
   assert_release_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && $fell(rts_n)) |-> ($past(lvl) < $past(lim)));

   // R9: timer held clear in manual mode
   assert_manual_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!auto_en) |-> (tmr_cnt == '0));
endmodule

bind rx_rts_flow rx_rts_flow_chk #(
   .CNT_W(CNT_W), .LO_THR(LO_THR), .HI_THR(HI_THR), .TMR_W(TMR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fill_cnt (fill_cnt),
   .start_det(start_det),
   .host_read(host_read),
   .auto_en  (auto_en),
   .thr_sel  (thr_sel),
   .wlen     (wlen),
   .rts_n    (rts_n),
   .tmr_cnt  (tmr_cnt)
);

// File: tb/sim_rx_rts_flow.sv
module sim_rx_rts_flow;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 24;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] fill_cnt;
   logic       start_det, host_read, bit_tick, auto_en, thr_sel, man_assert;
   logic [1:0] wlen;
   logic       rts_n;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_rts_flow u0 (
      .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .start_det(start_det),
      .host_read(host_read), .bit_tick(bit_tick), .auto_en(auto_en),
      .thr_sel(thr_sel), .man_assert(man_assert), .wlen(wlen), .rts_n(rts_n)
   );

   // {req[3:0], auto, sel, man, fill[3:0], start, rd, tick, exp}
   localparam logic [14:0] VEC [NVEC] = '{
      {4'd1, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0}, // R1 idle
      {4'd3, 1'b1,1'b0,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0}, // R3 level alone
      {4'd3, 1'b1,1'b0,1'b0,4'd1,1'b1,1'b0,1'b0,1'b0}, // R3 start below
      {4'd2, 1'b1,1'b0,1'b0,4'd2,1'b1,1'b0,1'b0,1'b1}, // R2 stop
      {4'd7, 1'b1,1'b0,1'b0,4'd2,1'b0,1'b0,1'b1,1'b1}, // R7 t=4
      {4'd7, 1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,1'b1,1'b1}, // R7 t=3
      {4'd7, 1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,1'b1,1'b1}, // R7 t=2
      {4'd7, 1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,1'b1,1'b1}, // R7 t=1
      {4'd7, 1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,1'b1,1'b1}, // R7 t=0
      {4'd4, 1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,1'b0,1'b0}, // R4 release
      {4'd5, 1'b1,1'b1,1'b0,4'd3,1'b1,1'b0,1'b0,1'b0}, // R5 level 3
      {4'd10,1'b1,1'b1,1'b0,4'd4,1'b1,1'b1,1'b0,1'b0}, // R10 read same cycle
      {4'd5, 1'b1,1'b1,1'b0,4'd4,1'b1,1'b0,1'b0,1'b1}, // R5 stop
      {4'd7, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1}, // R7
      {4'd7, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1}, // R7
      {4'd7, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1}, // R7
      {4'd7, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1}, // R7
      {4'd7, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1}, // R7 t=0
      {4'd8, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1}, // R8 cond false
      {4'd6, 1'b1,1'b1,1'b0,4'd4,1'b0,1'b1,1'b0,1'b0}, // R6 level 3 via read
      {4'd9, 1'b0,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0}, // R9 manual assert
      {4'd9, 1'b0,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b1}, // R9 manual release
      {4'd9, 1'b0,1'b0,1'b0,4'd5,1'b1,1'b0,1'b0,1'b1}, // R9 start ignored
      {4'd9, 1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0}  // R9 back to auto
   };

   task automatic check(input string req, input logic exp);
      checks++;
      if (rts_n !== exp) begin
         fails++;
         $display("FAIL %s: rts_n=%b expected=%b at %0t", req, rts_n, exp, $time);
      end
   endtask

   task automatic drive(input logic a, s, m, input logic [3:0] f,
                        input logic st, rd, tk);
      auto_en = a; thr_sel = s; man_assert = m; fill_cnt = f;
      start_det = st; host_read = rd; bit_tick = tk;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      wlen  = 2'd0;
      drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
      #(CLK_PERIOD * 3);
      check("R1", 1'b0);            // asserted during reset
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4],
               VEC[i][3], VEC[i][2], VEC[i][1]);
         @(negedge clk);
         check($sformatf("R%0d", int'(VEC[i][14:11])), VEC[i][0]);
      end

      // R7 with 8 data bits: eight ticks hold the line high
      wlen = 2'd3;
      drive(1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      check("R7", 1'b1);
      for (int k = 0; k < 8; k++) begin
         drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
         @(negedge clk);
         check("R7", 1'b1);
         drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
         @(negedge clk);
         if (k < 7) check("R7", 1'b1);
         else       check("R7", 1'b0);
      end

      // R8 with the two-word threshold: expired but level still 2
      wlen = 2'd0;
      drive(1'b1, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      check("R2", 1'b1);
      for (int k = 0; k < 5; k++) begin
         drive(1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b1);
         @(negedge clk);
      end
      drive(1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R8", 1'b1);
      drive(1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 1'b0);  // extra start while held
      @(negedge clk);
      check("R8", 1'b1);
      drive(1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0);  // read drops level to 1
      @(negedge clk);
      check("R4", 1'b0);

      // R9: manual bit ignored in automatic mode only while auto_en=1
      drive(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R9", 1'b0);
      drive(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
      #1;
      check("R9", 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule